// File: doc/BRIEF.md
# Stop-Grant Clock Enable Sequencer

This block puts the internal units of a processor-style core to sleep on request and wakes them again. A raw stop request arrives on an active-low pin that has no timing relation to the block clock. Once the request has been synchronized and has proven stable, the block asks the bus interface to run one acknowledge transaction. It then holds that request until the bus grants it.

When the grant arrives, the block withdraws the clock enables of every core unit. The bus-interface unit and the interrupt-controller unit keep their enables, so snoops and interrupts are still served while the core sleeps. The block only produces enable levels. The bus clock and the gating cells belong to other logic.

When the request pin returns high, the block raises every enable again. It also pulses a resume indication for one cycle and then returns to normal running. If the request is withdrawn before the acknowledge has been granted, the acknowledge still completes, and the block then passes directly to the resume step.

Top module: `stop_grant_ctrl`

## Requirements
- R1: `stop_req_ni` passes through a two-flop synchronizer and must stay stable for two further cycles. If the pin falls just before a rising edge, `ack_req_o` first reads high after the fifth rising edge, counting that edge as the first. It is still low after the fourth.
- R2: A low pulse on `stop_req_ni` that lasts a single clock cycle is ignored: `ack_req_o` stays low and `state_o` stays RUN.
- R3: After a request is accepted, `state_o` is ACK_PENDING and `ack_req_o` is high. `ack_req_o` stays high until an edge samples `ack_gnt_i` high. It is low in every other state, so exactly one transaction is requested per accepted request.
- R4: While `state_o` is STOP_GRANT, every `unit_en_o` bit other than the bus and interrupt-controller bits is low. Those bits drop at the edge that samples the grant, stay high during ACK_PENDING, and are high in every other state.
- R5: The bus-unit bit (`BUS_IDX`, default 0) and the interrupt-controller bit (`IRQ_IDX`, default 1) of `unit_en_o` are high in every state.
- R6: While in STOP_GRANT, a release of `stop_req_ni` is filtered with the same latency as R1. The block then spends one cycle in RESUME with `resume_o` high and all enables high, and on the next cycle it is in RUN with `resume_o` low.
- R7: If the request is released while the block is in ACK_PENDING, the acknowledge request stays up until granted. The grant then moves the block straight to RESUME with all enables high, never entering STOP_GRANT.
- R8: `state_o` encodes RUN=0, ACK_PENDING=1, STOP_GRANT=2 and RESUME=3. After reset the block is in RUN with `ack_req_o` low, `resume_o` low and all enables high.
- R9: A high `ack_gnt_i` outside ACK_PENDING has no effect. In particular, it does not move the block out of RUN or out of STOP_GRANT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_req_ni | input | 1 | Raw asynchronous stop request, active low |
| ack_gnt_i | input | 1 | Bus grant for the acknowledge transaction |
| ack_req_o | output | 1 | Request to run the stop-grant acknowledge transaction |
| unit_en_o | output | NUM_UNITS | Per-unit clock enables |
| state_o | output | 2 | Sequencer state |
| resume_o | output | 1 | One-cycle resume indication to the core |

## Verification
The hardest situation to reach is a release of the request while the acknowledge is still waiting for its grant. The bench reaches it by withholding the grant long enough for the release to clear the full synchronizer and filter path before granting. The bench also reaches two cases by counting edges from a pin change made at a falling edge: the stability filter rejecting a one-cycle glitch, and the exact edge on which the request is first acted upon.

// File: rtl/stpg_pkg.sv
package stpg_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_ACK_PEND = 2'd1,
    ST_STOPPED  = 2'd2,
    ST_RESUME   = 2'd3
  } stpg_state_e;
endpackage

// File: rtl/stpg_req_filter.sv
module stpg_req_filter #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned STABLE_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_ni,
  output logic req_o
);
  localparam int unsigned CNT_W = $clog2(STABLE_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   req_q;
  logic                   req_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_ni};
  end

  assign req_sync = ~sync_q[SYNC_STAGES-1];

  // filtered level changes only after STABLE_CYCLES consecutive disagreements
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (req_sync == req_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_W'(STABLE_CYCLES - 1)) begin
      cnt_q <= '0;
      req_q <= req_sync;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/stpg_fsm.sv
module stpg_fsm
  import stpg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        gnt_i,
  output stpg_state_e state_o
);
  stpg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:      if (req_i) state_d = ST_ACK_PEND;
      ST_ACK_PEND: if (gnt_i) state_d = req_i ? ST_STOPPED : ST_RESUME;
      ST_STOPPED:  if (!req_i) state_d = ST_RESUME;
      ST_RESUME:   state_d = ST_RUN;
      default:     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/stpg_en_map.sv
module stpg_en_map #(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned BUS_IDX   = 0,
  parameter int unsigned IRQ_IDX   = 1
) (
  input  logic                 stopped_i,
  output logic [NUM_UNITS-1:0] en_o
);
  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    if (i == BUS_IDX || i == IRQ_IDX) begin : g_keep
      assign en_o[i] = 1'b1;
    end else begin : g_gate
      assign en_o[i] = ~stopped_i;
    end
  end
endmodule

// File: rtl/stop_grant_ctrl.sv
module stop_grant_ctrl
  import stpg_pkg::*;
#(
  parameter int unsigned NUM_UNITS     = 8,
  parameter int unsigned BUS_IDX       = 0,
  parameter int unsigned IRQ_IDX       = 1,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned STABLE_CYCLES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 stop_req_ni,
  input  logic                 ack_gnt_i,
  output logic                 ack_req_o,
  output logic [NUM_UNITS-1:0] unit_en_o,
  output logic [1:0]           state_o,
  output logic                 resume_o
);
  logic        req_filt;
  stpg_state_e state;

  stpg_req_filter #(
    .SYNC_STAGES  (SYNC_STAGES),
    .STABLE_CYCLES(STABLE_CYCLES)
  ) u_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_ni(stop_req_ni),
    .req_o (req_filt)
  );

  stpg_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_filt),
    .gnt_i  (ack_gnt_i),
    .state_o(state)
  );

  stpg_en_map #(
    .NUM_UNITS(NUM_UNITS),
    .BUS_IDX  (BUS_IDX),
    .IRQ_IDX  (IRQ_IDX)
  ) u_en (
    .stopped_i(state == ST_STOPPED),
    .en_o     (unit_en_o)
  );

  assign ack_req_o = (state == ST_ACK_PEND);
  assign resume_o  = (state == ST_RESUME);
  assign state_o   = state;
endmodule

// File: rtl/stop_grant_ctrl_chk.sv
module stop_grant_ctrl_chk #(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned BUS_IDX   = 0,
  parameter int unsigned IRQ_IDX   = 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ack_gnt_i,
  input logic                 ack_req_o,
  input logic [NUM_UNITS-1:0] unit_en_o,
  input logic [1:0]           state_o,
  input logic                 resume_o
);
  logic [NUM_UNITS-1:0] core_mask;
  always_comb begin
    core_mask = '1;
    core_mask[BUS_IDX] = 1'b0;
    core_mask[IRQ_IDX] = 1'b0;
  end

  a_r3_ack_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_req_o && !ack_gnt_i) |=> ack_req_o);

  a_r3_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_req_o && ack_gnt_i) |=> !ack_req_o);

  a_r4_core_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) |-> ((unit_en_o & core_mask) == '0));

  a_r4_core_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'd2) |-> ((unit_en_o & core_mask) == core_mask));

  a_r5_keep_units: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_en_o[BUS_IDX] && unit_en_o[IRQ_IDX]);

  a_r6_resume_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> (!resume_o && state_o == 2'd0));

  a_r7_stop_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && !ack_gnt_i) |=> state_o == 2'd1);

  a_r9_stopped_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) |=> (state_o == 2'd2 || state_o == 2'd3));
endmodule

bind stop_grant_ctrl stop_grant_ctrl_chk #(
  .NUM_UNITS(NUM_UNITS),
  .BUS_IDX  (BUS_IDX),
  .IRQ_IDX  (IRQ_IDX)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ack_gnt_i(ack_gnt_i),
  .ack_req_o(ack_req_o),
  .unit_en_o(unit_en_o),
  .state_o  (state_o),
  .resume_o (resume_o)
);

// File: tb/stop_grant_ctrl_tb.sv
module stop_grant_ctrl_tb;
  localparam int NU = 8;
  localparam logic [NU-1:0] ALL_ON  = '1;
  localparam logic [NU-1:0] KEEP_ON = 8'b0000_0011;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          stop_req_ni = 1'b1;
  logic          ack_gnt_i = 1'b0;
  logic          ack_req_o;
  logic [NU-1:0] unit_en_o;
  logic [1:0]    state_o;
  logic          resume_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  stop_grant_ctrl u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_req_ni(stop_req_ni),
    .ack_gnt_i  (ack_gnt_i),
    .ack_req_o  (ack_req_o),
    .unit_en_o  (unit_en_o),
    .state_o    (state_o),
    .resume_o   (resume_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R8 reset state", state_o, 0);
    chk("R8 reset ack", ack_req_o, 0);
    chk("R8 reset resume", resume_o, 0);
    chk("R8 reset enables", unit_en_o, ALL_ON);
  endtask

  task automatic t_glitch();
    stop_req_ni = 1'b0;
    tick();
    stop_req_ni = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick();
      chk("R2 glitch ack", ack_req_o, 0);
      chk("R2 glitch state", state_o, 0);
    end
  endtask

  task automatic t_grant_in_run();
    ack_gnt_i = 1'b1;
    tick(3);
    chk("R9 grant in RUN", state_o, 0);
    chk("R9 grant in RUN enables", unit_en_o, ALL_ON);
    ack_gnt_i = 1'b0;
  endtask

  task automatic t_full_cycle();
    stop_req_ni = 1'b0;
    tick(4);
    chk("R1 not yet after 4 edges", ack_req_o, 0);
    tick();
    chk("R1 ack after 5 edges", ack_req_o, 1);
    chk("R3 state ack pending", state_o, 1);
    tick(3);
    chk("R3 ack held without grant", ack_req_o, 1);
    chk("R4 enables on while pending", unit_en_o, ALL_ON);
    ack_gnt_i = 1'b1;
    tick();
    ack_gnt_i = 1'b0;
    chk("R4 stopped state", state_o, 2);
    chk("R4 core enables dropped", unit_en_o, KEEP_ON);
    chk("R3 ack released", ack_req_o, 0);
    ack_gnt_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R3 single ack", ack_req_o, 0);
      chk("R9 grant in STOP_GRANT", state_o, 2);
      chk("R5 bus/irq kept", unit_en_o & KEEP_ON, KEEP_ON);
    end
    ack_gnt_i = 1'b0;
    stop_req_ni = 1'b1;
    tick(4);
    chk("R6 still stopped", state_o, 2);
    tick();
    chk("R6 resume state", state_o, 3);
    chk("R6 resume pulse", resume_o, 1);
    chk("R6 enables restored", unit_en_o, ALL_ON);
    tick();
    chk("R6 back to RUN", state_o, 0);
    chk("R6 resume ends", resume_o, 0);
  endtask

  task automatic t_early_release();
    stop_req_ni = 1'b0;
    tick(5);
    chk("R7 pending", state_o, 1);
    stop_req_ni = 1'b1;
    tick(8);
    chk("R7 ack still pending", ack_req_o, 1);
    chk("R7 enables on", unit_en_o, ALL_ON);
    ack_gnt_i = 1'b1;
    tick();
    ack_gnt_i = 1'b0;
    chk("R7 straight to resume", state_o, 3);
    chk("R7 resume pulse", resume_o, 1);
    chk("R7 enables on in resume", unit_en_o, ALL_ON);
    tick();
    chk("R7 back to RUN", state_o, 0);
  endtask

  initial begin
    tick(2);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_glitch();
    t_grant_in_run();
    t_full_cycle();
    t_early_release();
    t_full_cycle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule